// File: doc/BRIEF.md
# Paired-Decision SAR Conversion Sequencer

This block sequences one successive-approximation channel of 7 bits. Each conversion takes five clock cycles. The first cycle samples the input. The second connects the bias node to the DC level and takes the most significant decision from the voltage comparator. Each of the last three cycles resolves two bits at once. The voltage comparator gives the upper bit of the pair. A time comparator, strobed later through an external programmable delay line, gives the lower bit.

The sequencer drives a bank of capacitive-DAC intermediate nodes with 2-bit level selects. Each decided bit pushes its node to the maximum or minimum reference. A node is released to float once the next pair of nodes takes over. When a conversion finishes, every node returns to the mid reference. It also drives the three analog switches around the DAC output node, and it raises a strobe request that carries the index of the delay code the delay line must use. The result is registered and flagged with a one-cycle valid pulse.

Top module: `dual_decide_sar`

## Requirements
- R1: After reset the block is idle. `busy`, `resultValid`, `strobeReq` and all three switch controls are low, `result` is 0, and every node select reads mid. Node select codes are 00 float, 01 min, 10 mid and 11 max, and node n occupies `nodeSel[2n+1:2n]`: A is node 0 and F is node 5.
- R2: A high `start` sampled while idle begins a conversion, and `busy` is high for exactly the next five cycles. `start` is ignored while `busy` is high.
- R3: In conversion cycle 1 the output-reset and sampling switches are closed, the DC-connect switch is open, and all nodes read mid.
- R4: In cycle 2 only the DC-connect switch is closed. The value of `voltCmp` at the end of cycle 2 becomes result bit 6.
- R5: In cycles 3, 4 and 5, `strobeReq` is high with `strobeIdx` equal to 1, 2 and 3. At the end of the cycle with index k, `voltCmp` becomes result bit 6-2k+1 and `timeCmp` becomes result bit 6-2k. Comparator inputs are ignored in all other cycles.
- R6: Node A reads max (11) in cycle 3 when bit 6 is 1, and min (01) when it is 0. It floats (00) in cycles 4 and 5.
- R7: In cycle 4, nodes B and C are driven from bits 5 and 4 and float in cycle 5. In cycle 5, nodes D and E are driven from bits 3 and 2. Before its own cycle, each of these nodes reads mid.
- R8: Node F reads mid in every cycle.
- R9: In the cycle after cycle 5, `resultValid` is high for one cycle, `result` carries the 7 decided bits, `busy` is low and all nodes read mid. `result` keeps its value until the next conversion completes.
- R10: A `start` sampled in the valid cycle is accepted, so conversions can run back to back with a one-cycle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion when idle |
| voltCmp | input | 1 | Voltage comparator decision |
| timeCmp | input | 1 | Time comparator decision |
| busy | output | 1 | Conversion in progress |
| rstSwitch | output | 1 | Close output-node reset switch |
| sampleSwitch | output | 1 | Close input sampling switch |
| dcSwitch | output | 1 | Close bias-to-DC switch |
| strobeReq | output | 1 | Time comparator strobe request |
| strobeIdx | output | 2 | Delay code index for the strobe (1..3) |
| nodeSel | output | 12 | 2-bit level select per DAC node |
| result | output | 7 | Converted code |
| resultValid | output | 1 | One-cycle result valid pulse |

## Verification
The bench builds the block with its default of three paired steps, which gives a 7-bit result and six DAC nodes. At that size it can sweep all 128 codes. Each sweep feeds comparator decisions matched to the target code and checks the node levels cycle by cycle, including the float and drive pattern for every bit combination. Chained starts in the valid cycle cover back-to-back operation. Start pulses injected mid-conversion cover the rule that `start` is ignored while busy. Opposite-polarity comparator values in the cycles with no decision show that those inputs are ignored.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int PAIR_IDX_W = 4;

  typedef enum logic [1:0] {
    NODE_FLOAT = 2'b00,
    NODE_MIN   = 2'b01,
    NODE_MID   = 2'b10,
    NODE_MAX   = 2'b11
  } nodeLevel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_MSB,
    ST_PAIR
  } seqState_e;

  typedef struct packed {
    logic                  clearBits;
    logic                  takeMsb;
    logic                  takePair;
    logic                  lastPair;
    logic [PAIR_IDX_W-1:0] pairIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/dds_ctrl.sv
module dds_ctrl
  import dds_pkg::*;
#(
  parameter int NUM_PAIRS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t strb,
  output logic        busy,
  output logic        rstSwitch,
  output logic        sampleSwitch,
  output logic        dcSwitch
);
  localparam logic [PAIR_IDX_W-1:0] LastIdx = PAIR_IDX_W'(NUM_PAIRS);

  seqState_e stateQ, stateD;
  logic [PAIR_IDX_W-1:0] idxQ, idxD;

  always_comb begin
    stateD = stateQ;
    idxD   = idxQ;
    case (stateQ)
      ST_IDLE:   if (start) stateD = ST_SAMPLE;
      ST_SAMPLE: stateD = ST_MSB;
      ST_MSB: begin
        stateD = ST_PAIR;
        idxD   = PAIR_IDX_W'(1);
      end
      ST_PAIR: begin
        if (idxQ == LastIdx) begin
          stateD = ST_IDLE;
          idxD   = '0;
        end else begin
          idxD = idxQ + PAIR_IDX_W'(1);
        end
      end
      default: begin
        stateD = ST_IDLE;
        idxD   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
    end
  end

  always_comb begin
    strb.clearBits = (stateQ == ST_SAMPLE);
    strb.takeMsb   = (stateQ == ST_MSB);
    strb.takePair  = (stateQ == ST_PAIR);
    strb.lastPair  = (stateQ == ST_PAIR) && (idxQ == LastIdx);
    strb.pairIdx   = (stateQ == ST_PAIR) ? idxQ : '0;
  end

  assign busy         = (stateQ != ST_IDLE);
  assign rstSwitch    = (stateQ == ST_SAMPLE);
  assign sampleSwitch = (stateQ == ST_SAMPLE);
  assign dcSwitch     = (stateQ == ST_MSB);
endmodule

// File: rtl/dds_datapath.sv
module dds_datapath
  import dds_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  localparam int RES_BITS  = 2 * NUM_PAIRS + 1,
  localparam int NUM_NODES = 2 * NUM_PAIRS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strb,
  input  logic                   voltCmp,
  input  logic                   timeCmp,
  output logic [2*NUM_NODES-1:0] nodeSel,
  output logic [RES_BITS-1:0]    result,
  output logic                   resultValid
);
  logic [RES_BITS-1:0] bitsQ, bitsD;

  function automatic logic [1:0] driveLevel(input logic bitVal);
    return bitVal ? NODE_MAX : NODE_MIN;
  endfunction

  always_comb begin
    bitsD = bitsQ;
    if (strb.clearBits) bitsD = '0;
    if (strb.takeMsb) bitsD[RES_BITS-1] = voltCmp;
    if (strb.takePair) begin
      for (int k = 1; k <= NUM_PAIRS; k++) begin
        if (strb.pairIdx == PAIR_IDX_W'(k)) begin
          bitsD[RES_BITS-2*k]   = voltCmp;
          bitsD[RES_BITS-2*k-1] = timeCmp;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitsQ       <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      bitsQ       <= bitsD;
      resultValid <= strb.lastPair;
      if (strb.lastPair) result <= bitsD;
    end
  end

  // node A: driven by the first decision during the first paired step
  assign nodeSel[1:0] = !strb.takePair ? NODE_MID :
                        (strb.pairIdx == PAIR_IDX_W'(1)) ? driveLevel(bitsQ[RES_BITS-1]) :
                        NODE_FLOAT;

  // node pairs: pair g is driven in paired step g+1 and floated afterwards
  for (genvar g = 1; g < NUM_PAIRS; g++) begin : g_pair
    localparam logic [PAIR_IDX_W-1:0] OwnStep = PAIR_IDX_W'(g + 1);
    logic early, active;
    assign early  = !strb.takePair || (strb.pairIdx < OwnStep);
    assign active = (strb.pairIdx == OwnStep);
    assign nodeSel[2*(2*g-1) +: 2] = early  ? NODE_MID :
                                     active ? driveLevel(bitsQ[RES_BITS-2*g]) : NODE_FLOAT;
    assign nodeSel[2*(2*g) +: 2]   = early  ? NODE_MID :
                                     active ? driveLevel(bitsQ[RES_BITS-2*g-1]) : NODE_FLOAT;
  end

  // spare node kept for delay trimming, parked at mid
  assign nodeSel[2*NUM_NODES-1 -: 2] = NODE_MID;
endmodule

// File: rtl/dual_decide_sar.sv
module dual_decide_sar
  import dds_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  localparam int RES_BITS  = 2 * NUM_PAIRS + 1,
  localparam int NUM_NODES = 2 * NUM_PAIRS,
  localparam int IDX_W     = $clog2(NUM_PAIRS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   voltCmp,
  input  logic                   timeCmp,
  output logic                   busy,
  output logic                   rstSwitch,
  output logic                   sampleSwitch,
  output logic                   dcSwitch,
  output logic                   strobeReq,
  output logic [IDX_W-1:0]       strobeIdx,
  output logic [2*NUM_NODES-1:0] nodeSel,
  output logic [RES_BITS-1:0]    result,
  output logic                   resultValid
);
  ctrlStrobe_t strb;

  dds_ctrl #(.NUM_PAIRS(NUM_PAIRS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .strb        (strb),
    .busy        (busy),
    .rstSwitch   (rstSwitch),
    .sampleSwitch(sampleSwitch),
    .dcSwitch    (dcSwitch)
  );

  dds_datapath #(.NUM_PAIRS(NUM_PAIRS)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .voltCmp    (voltCmp),
    .timeCmp    (timeCmp),
    .nodeSel    (nodeSel),
    .result     (result),
    .resultValid(resultValid)
  );

  assign strobeReq = strb.takePair;
  assign strobeIdx = strb.pairIdx[IDX_W-1:0];
endmodule

// File: rtl/dds_checker.sv
module dds_checker #(
  parameter int NUM_PAIRS = 3,
  localparam int RES_BITS  = 2 * NUM_PAIRS + 1,
  localparam int NUM_NODES = 2 * NUM_PAIRS,
  localparam int IDX_W     = $clog2(NUM_PAIRS + 1)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic                   busy,
  input logic                   rstSwitch,
  input logic                   sampleSwitch,
  input logic                   dcSwitch,
  input logic                   strobeReq,
  input logic [IDX_W-1:0]       strobeIdx,
  input logic [2*NUM_NODES-1:0] nodeSel,
  input logic [RES_BITS-1:0]    result,
  input logic                   resultValid
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NUM_PAIRS);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !strobeReq && !dcSwitch && !sampleSwitch && !rstSwitch);

  p_start_sample_r2: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy && rstSwitch && sampleSwitch && !dcSwitch);

  p_sample_to_dc_r4: assert property (@(posedge clk) disable iff (!rstN)
    sampleSwitch |=> dcSwitch && !sampleSwitch && !rstSwitch && busy);

  p_dc_to_first_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    dcSwitch |=> strobeReq && strobeIdx == IDX_W'(1));

  p_strobe_advance_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobeReq && strobeIdx != LastIdx |=> strobeReq && strobeIdx == IDX_W'($past(strobeIdx) + 1'b1));

  p_node_a_float_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobeReq && strobeIdx > IDX_W'(1) |-> nodeSel[1:0] == 2'b00);

  p_spare_mid_r8: assert property (@(posedge clk) disable iff (!rstN)
    nodeSel[2*NUM_NODES-1 -: 2] == 2'b10);

  p_last_to_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobeReq && strobeIdx == LastIdx |=> resultValid && !busy);

  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));

  p_switch_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dcSwitch, sampleSwitch}));
endmodule

bind dual_decide_sar dds_checker #(.NUM_PAIRS(NUM_PAIRS)) u_dds_checker (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .busy        (busy),
  .rstSwitch   (rstSwitch),
  .sampleSwitch(sampleSwitch),
  .dcSwitch    (dcSwitch),
  .strobeReq   (strobeReq),
  .strobeIdx   (strobeIdx),
  .nodeSel     (nodeSel),
  .result      (result),
  .resultValid (resultValid)
);

// File: tb/dual_decide_sar_bench.sv
`timescale 1ns/1ps
module dual_decide_sar_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic voltCmp = 1'b0;
  logic timeCmp = 1'b0;
  logic busy, rstSwitch, sampleSwitch, dcSwitch, strobeReq, resultValid;
  logic [1:0]  strobeIdx;
  logic [11:0] nodeSel;
  logic [6:0]  result;

  dual_decide_sar u_dual_decide_sar (
    .clk(clk), .rstN(rstN), .start(start), .voltCmp(voltCmp), .timeCmp(timeCmp),
    .busy(busy), .rstSwitch(rstSwitch), .sampleSwitch(sampleSwitch), .dcSwitch(dcSwitch),
    .strobeReq(strobeReq), .strobeIdx(strobeIdx), .nodeSel(nodeSel),
    .result(result), .resultValid(resultValid)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [6:0] expQ[$];
  logic [6:0] lastCode = '0;
  logic [6:0] monExp;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] lvl(input logic b);
    return b ? 2'b11 : 2'b01;
  endfunction

  function automatic logic [1:0] nodeAt(input int i);
    return nodeSel[2*i +: 2];
  endfunction

  // monitor: pops the scoreboard whenever a result is flagged
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R9 unexpected valid", result, 0);
      end else begin
        monExp = expQ.pop_front();
        chk(result == monExp, "R9 result code", result, monExp);
        lastCode = monExp;
      end
    end
  end

  // driver: one conversion, comparator decisions taken from the target code
  task automatic convert(input logic [6:0] code, input bit preStarted,
                         input bit chainNext, input bit poke);
    expQ.push_back(code);
    if (!preStarted) begin
      @(negedge clk);
      start = 1'b1;
    end
    @(negedge clk);  // cycle 1
    start = 1'b0;
    voltCmp = ~code[6];
    timeCmp = ~code[4];
    chk({busy, rstSwitch, sampleSwitch, dcSwitch, strobeReq} == 5'b11100, "R3 sample switches",
        {busy, rstSwitch, sampleSwitch, dcSwitch, strobeReq}, 5'b11100);
    chk(nodeSel == 12'haaa, "R3 nodes mid", nodeSel, 12'haaa);
    chk(result == lastCode, "R9 result hold", result, lastCode);
    @(negedge clk);  // cycle 2
    chk({busy, rstSwitch, sampleSwitch, dcSwitch, strobeReq} == 5'b10010, "R4 dc connect",
        {busy, rstSwitch, sampleSwitch, dcSwitch, strobeReq}, 5'b10010);
    voltCmp = code[6];
    timeCmp = ~code[6];
    @(negedge clk);  // cycle 3
    chk({busy, strobeReq, strobeIdx} == 4'b1101, "R5 strobe index 1", {busy, strobeReq, strobeIdx}, 4'b1101);
    chk(nodeAt(0) == lvl(code[6]), "R6 node A driven", nodeAt(0), lvl(code[6]));
    for (int i = 1; i < 5; i++) chk(nodeAt(i) == 2'b10, "R7 later nodes mid", nodeAt(i), 2'b10);
    chk(nodeAt(5) == 2'b10, "R8 spare mid", nodeAt(5), 2'b10);
    voltCmp = code[5];
    timeCmp = code[4];
    if (poke) start = 1'b1;
    @(negedge clk);  // cycle 4
    start = 1'b0;
    chk({busy, strobeReq, strobeIdx} == 4'b1110, "R5 strobe index 2", {busy, strobeReq, strobeIdx}, 4'b1110);
    chk(nodeAt(0) == 2'b00, "R6 node A float", nodeAt(0), 0);
    chk(nodeAt(1) == lvl(code[5]), "R7 node B", nodeAt(1), lvl(code[5]));
    chk(nodeAt(2) == lvl(code[4]), "R7 node C", nodeAt(2), lvl(code[4]));
    chk(nodeAt(3) == 2'b10 && nodeAt(4) == 2'b10, "R7 D E mid", nodeSel[9:6], 4'b1010);
    chk(nodeAt(5) == 2'b10, "R8 spare mid", nodeAt(5), 2'b10);
    voltCmp = code[3];
    timeCmp = code[2];
    @(negedge clk);  // cycle 5
    chk({busy, strobeReq, strobeIdx} == 4'b1111, "R5 strobe index 3", {busy, strobeReq, strobeIdx}, 4'b1111);
    chk(nodeSel[5:0] == 6'b0, "R6 R7 A B C float", nodeSel[5:0], 0);
    chk(nodeAt(3) == lvl(code[3]), "R7 node D", nodeAt(3), lvl(code[3]));
    chk(nodeAt(4) == lvl(code[2]), "R7 node E", nodeAt(4), lvl(code[2]));
    chk(nodeAt(5) == 2'b10, "R8 spare mid", nodeAt(5), 2'b10);
    chk(result == lastCode, "R9 result hold", result, lastCode);
    voltCmp = code[1];
    timeCmp = code[0];
    @(negedge clk);  // valid cycle
    chk(!busy && resultValid && !strobeReq, "R9 valid idle", {busy, resultValid, strobeReq}, 3'b010);
    chk(nodeSel == 12'haaa, "R9 nodes back to mid", nodeSel, 12'haaa);
    voltCmp = ~voltCmp;
    timeCmp = ~timeCmp;
    if (chainNext) begin
      start = 1'b1;  // R10 start in valid cycle
    end else begin
      @(negedge clk);
      chk(!busy && !resultValid, "R2 no extra conversion", {busy, resultValid}, 0);
      chk(result == code, "R9 result held", result, code);
    end
  endtask

  initial begin
    bit chained;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, resultValid, strobeReq, rstSwitch, sampleSwitch, dcSwitch} == 6'b0, "R1 reset outputs",
        {busy, resultValid, strobeReq, rstSwitch, sampleSwitch, dcSwitch}, 0);
    chk(result == 7'd0, "R1 reset result", result, 0);
    chk(nodeSel == 12'haaa, "R1 reset nodes mid", nodeSel, 12'haaa);
    chained = 1'b0;
    for (int c = 0; c < 128; c++) begin
      bit chainNext;
      chainNext = (c % 3 == 1) && (c != 127);
      convert(7'(c), chained, chainNext, (c % 5 == 0));
      chained = chainNext;
    end
    convert(7'h55, 1'b0, 1'b1, 1'b1);  // R10 chained pair
    convert(7'h2a, 1'b1, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R9 all results seen", expQ.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule